// File: doc/BRIEF.md
# Calibration Region Write Lock

This block guards a calibration area of RAM against stray writes. Every watchdog reset starts a cycle timer. Software can open the protected area only by issuing one decoded request strobe while the timer sits inside a narrow acceptance window. A strobe that comes before the window opens locks the area out until the next reset. A strobe that comes after the window closes has no effect.

The block drives an active-low unlock flag. It also drives a qualified write enable for the RAM. A write request aimed at the protected address range reaches the RAM only while the unlock flag is low. Writes to any other address pass straight through.

The control is a five-state machine held in `lock_state_e`:
- `ST_ARMED`: the reset state.
- `ST_WINDOW`: the acceptance window is open.
- `ST_UNLOCKED`: the protected range is writable.
- `ST_LOCKOUT`: a strobe came too early.
- `ST_EXPIRED`: the window closed with no strobe.

Its transitions are:
- Arm-to-window, when the timer reaches `OPEN_CYC`.
- Early strobe from `ST_ARMED` to `ST_LOCKOUT`.
- Accepted strobe from `ST_WINDOW` to `ST_UNLOCKED`.
- Window timeout from `ST_WINDOW` to `ST_EXPIRED`, after offset `CLOSE_CYC` passes with no strobe.

`ST_UNLOCKED`, `ST_LOCKOUT` and `ST_EXPIRED` are held until reset.

Top module: `cal_write_lock`

## Requirements
- R1: While `rst_n` is low, `unlock_n` is 1, the machine is in `ST_ARMED` and the timer is zero.
- R2: A request exists only when `bus_en` is 1 and `addr[5]`=1, `addr[4]`=1, `addr[3]`=0. The other address bits are ignored. Any other combination, or `bus_en`=0, changes nothing.
- R3: A request is said to have offset k when it is sampled at the (k+1)-th rising edge after `rst_n` goes high. The acceptance window is `OPEN_CYC` <= k <= `CLOSE_CYC`. The defaults are 8192 and 8200, which is 4096 to 4100 µs at 2 MHz.
- R4: A request inside the window drives `unlock_n` to 0 from that edge on. It stays 0 until reset, and later requests do not change it.
- R5: A request with k < `OPEN_CYC` enters lockout. `unlock_n` then stays 1 until reset, even if a later request falls inside the window.
- R6: A request with k > `CLOSE_CYC` leaves `unlock_n` at 1.
- R7: For a write to an address in `PROT_LO`..`PROT_HI` (default 0x0040..0x1FFF), `ram_we` = `wr_req` AND NOT `unlock_n`.
- R8: For any address outside that range, `ram_we` = `wr_req`.
- R9: A reset after lockout or unlock re-arms the machine, so a fresh in-window request unlocks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (2 MHz in the intended use) |
| rst_n | input | 1 | Active-low watchdog reset; re-arms the lock |
| addr | input | ADDR_W | Processor address bus |
| bus_en | input | 1 | Bus enable strobe qualifying the request decode |
| wr_req | input | 1 | Processor write request |
| unlock_n | output | 1 | Active-low unlock flag for the protected range |
| ram_we | output | 1 | Qualified RAM write enable |

## Verification
The bench builds the block with `OPEN_CYC`=16 and `CLOSE_CYC`=20. With these values every request offset from 0 to 24 can be swept, covering both window edges and the late side, at a few dozen cycles per trial. After each trial the bench sweeps the write gate across addresses on and just beside both range limits. It also tries all eight codes of `addr[5:3]`, plus a strobe with `bus_en` low, before a valid in-window request, so that only the decoding code causes lockout.

// File: rtl/cal_lock_pkg.sv
package cal_lock_pkg;

    typedef enum logic [2:0] {
        ST_ARMED    = 3'd0,
        ST_WINDOW   = 3'd1,
        ST_UNLOCKED = 3'd2,
        ST_LOCKOUT  = 3'd3,
        ST_EXPIRED  = 3'd4
    } lock_state_e;

endpackage

// File: rtl/cal_req_decode.sv
module cal_req_decode (
    input  logic [2:0] addr_sel,   // addr[5:3]
    input  logic       bus_en,
    output logic       req
);
    // Request code: bit5=1, bit4=1, bit3=0
    assign req = bus_en & addr_sel[2] & addr_sel[1] & ~addr_sel[0];
endmodule

// File: rtl/cal_window_timer.sv
module cal_window_timer #(
    parameter int CNT_W = 14,
    parameter int SAT   = 8201
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != SAT_V)
            cnt <= cnt + 1'b1;
    end

    p_timer_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= SAT_V);

    p_timer_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != SAT_V) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/cal_lock_fsm.sv
module cal_lock_fsm
    import cal_lock_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int OPEN_CYC  = 8192,
    parameter int CLOSE_CYC = 8200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] cnt,
    output logic             unlock_n
);
    localparam logic [CNT_W-1:0] OPEN_V    = CNT_W'(OPEN_CYC);
    localparam logic [CNT_W-1:0] OPEN_M1   = CNT_W'(OPEN_CYC - 1);
    localparam logic [CNT_W-1:0] CLOSE_V   = CNT_W'(CLOSE_CYC);

    lock_state_e state, state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_ARMED;
        else
            state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ARMED: begin
                if (req)                  state_nxt = ST_LOCKOUT;   // early strobe
                else if (cnt == OPEN_M1)  state_nxt = ST_WINDOW;    // arm-to-window
            end
            ST_WINDOW: begin
                if (req)                  state_nxt = ST_UNLOCKED;  // accepted strobe
                else if (cnt == CLOSE_V)  state_nxt = ST_EXPIRED;   // window timeout
            end
            ST_UNLOCKED:                  state_nxt = ST_UNLOCKED;
            ST_LOCKOUT:                   state_nxt = ST_LOCKOUT;
            ST_EXPIRED:                   state_nxt = ST_EXPIRED;
            default:                      state_nxt = ST_LOCKOUT;
        endcase
    end

    // outputs
    always_comb begin
        unlock_n = (state != ST_UNLOCKED);
    end

    p_lockout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKOUT) |=> (state == ST_LOCKOUT));

    p_early_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cnt < OPEN_V) |=> unlock_n);

    p_late_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > CLOSE_V && unlock_n) |=> unlock_n);

    p_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cnt >= OPEN_V && cnt <= CLOSE_V && state != ST_LOCKOUT) |=> !unlock_n);

    p_unlock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock_n |=> !unlock_n);
endmodule

// File: rtl/cal_we_gate.sv
module cal_we_gate #(
    parameter int ADDR_W  = 16,
    parameter int PROT_LO = 'h0040,
    parameter int PROT_HI = 'h1FFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_req,
    input  logic              unlock_n,
    output logic              ram_we
);
    localparam logic [ADDR_W-1:0] LO_V = ADDR_W'(PROT_LO);
    localparam logic [ADDR_W-1:0] HI_V = ADDR_W'(PROT_HI);

    logic in_prot;

    always_comb begin
        in_prot = (addr >= LO_V) && (addr <= HI_V);
        ram_we  = wr_req & (~in_prot | ~unlock_n);
    end
endmodule

// File: rtl/cal_write_lock.sv
module cal_write_lock #(
    parameter int ADDR_W    = 16,
    parameter int OPEN_CYC  = 8192,
    parameter int CLOSE_CYC = 8200,
    parameter int PROT_LO   = 'h0040,
    parameter int PROT_HI   = 'h1FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bus_en,
    input  logic              wr_req,
    output logic              unlock_n,
    output logic              ram_we
);
    localparam int CNT_W = $clog2(CLOSE_CYC + 2);
    localparam int SAT   = CLOSE_CYC + 1;

    logic             req;
    logic [CNT_W-1:0] cnt;

    cal_req_decode u_dec (
        .addr_sel (addr[5:3]),
        .bus_en   (bus_en),
        .req      (req)
    );

    cal_window_timer #(.CNT_W(CNT_W), .SAT(SAT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    cal_lock_fsm #(.CNT_W(CNT_W), .OPEN_CYC(OPEN_CYC), .CLOSE_CYC(CLOSE_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .cnt      (cnt),
        .unlock_n (unlock_n)
    );

    cal_we_gate #(.ADDR_W(ADDR_W), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_gate (
        .addr     (addr),
        .wr_req   (wr_req),
        .unlock_n (unlock_n),
        .ram_we   (ram_we)
    );

    p_we_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && unlock_n && addr >= ADDR_W'(PROT_LO) && addr <= ADDR_W'(PROT_HI)) |-> !ram_we);

    p_we_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && (addr < ADDR_W'(PROT_LO) || addr > ADDR_W'(PROT_HI))) |-> ram_we);
endmodule

// File: tb/cal_write_lock_tb.sv
`timescale 1ns/1ps
module cal_write_lock_tb;
    localparam int OPEN  = 16;
    localparam int CLOSE = 20;
    localparam logic [15:0] REQ_ADDR = 16'h0030;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        bus_en = 1'b0;
    logic        wr_req = 1'b0;
    logic        unlock_n;
    logic        ram_we;

    int total = 0;
    int bad   = 0;
    int t     = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cal_write_lock #(.ADDR_W(16), .OPEN_CYC(OPEN), .CLOSE_CYC(CLOSE),
                     .PROT_LO('h0040), .PROT_HI('h1FFF)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .bus_en(bus_en),
        .wr_req(wr_req), .unlock_n(unlock_n), .ram_we(ram_we)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b (t=%0d)", tag, act, exp, t);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_en = 1'b0; wr_req = 1'b0; addr = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset unlock_n", unlock_n, 1'b1);
        rst_n = 1'b1;
        t = 0;
    endtask

    task automatic advance_to(input int k);
        while (t < k) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic pulse(input logic [15:0] a, input logic en);
        addr = a; bus_en = en;
        @(negedge clk);
        t++;
        bus_en = 1'b0; addr = '0;
    endtask

    task automatic we_sweep(input logic unlocked);
        logic [15:0] list [10] = '{16'h0000, 16'h003F, 16'h0040, 16'h0041, 16'h1000,
                                   16'h1FFE, 16'h1FFF, 16'h2000, 16'h8000, 16'hFFFF};
        for (int i = 0; i < 10; i++) begin
            logic inr;
            inr = (list[i] >= 16'h0040) && (list[i] <= 16'h1FFF);
            addr = list[i]; wr_req = 1'b1;
            #0.5;
            chk(inr ? "R7 protected write" : "R8 open write", ram_we, !inr || unlocked);
            wr_req = 1'b0;
            #0.5;
            chk(inr ? "R7 no request" : "R8 no request", ram_we, 1'b0);
        end
        addr = '0;
    endtask

    initial begin
        // R3 R4 R5 R6: sweep request offset
        for (int k = 0; k <= CLOSE + 4; k++) begin
            logic exp_unl;
            exp_unl = (k >= OPEN) && (k <= CLOSE);
            do_reset();
            advance_to(k);
            chk("R3 locked before request", unlock_n, 1'b1);
            pulse(REQ_ADDR, 1'b1);
            if (k < OPEN)        chk("R5 early request", unlock_n, 1'b1);
            else if (k > CLOSE)  chk("R6 late request", unlock_n, 1'b1);
            else                 chk("R4 in-window request", unlock_n, 1'b0);
            advance_to(t + 6);
            chk("R4 state held", unlock_n, !exp_unl);
            we_sweep(exp_unl);
        end

        // R2: decode sweep of addr[5:3] plus bus_en low
        for (int c = 0; c <= 8; c++) begin
            logic [15:0] a;
            logic en, locks;
            en    = (c < 8);
            a     = 16'hFF05 | (16'(c[2:0]) << 3);
            if (c == 8) a = 16'hFF35;
            locks = en && (c[2:0] == 3'b110);
            do_reset();
            advance_to(2);
            pulse(a, en);
            chk("R2 decode no unlock", unlock_n, 1'b1);
            advance_to(OPEN);
            pulse(REQ_ADDR, 1'b1);
            chk("R2 decode effect", unlock_n, locks);
        end

        // R5: lockout blocks later in-window request
        do_reset();
        advance_to(3);
        pulse(REQ_ADDR, 1'b1);
        advance_to(OPEN + 1);
        pulse(REQ_ADDR, 1'b1);
        chk("R5 lockout holds", unlock_n, 1'b1);
        we_sweep(1'b0);

        // R9: reset re-arms after lockout
        do_reset();
        advance_to(OPEN + 2);
        pulse(REQ_ADDR, 1'b1);
        chk("R9 re-armed unlock", unlock_n, 1'b0);
        pulse(REQ_ADDR, 1'b1);
        chk("R4 repeat request keeps unlock", unlock_n, 1'b0);

        // R1 / R9: reset from unlocked relocks
        do_reset();
        chk("R1 relocked after reset", unlock_n, 1'b1);
        advance_to(CLOSE);
        pulse(REQ_ADDR, 1'b1);
        chk("R9 upper window edge after re-arm", unlock_n, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule